// File: doc/BRIEF.md
# Branch Resolution Predictor Updater

This block sits between the execute stage and a branch predictor. Each cycle the execute stage may return one resolved-branch record: a valid flag, a 3-bit outcome code, a thread id, the fetch sequence number of the instruction, the resolved target address, a fault flag and a flag saying whether a prediction was attempted. The block turns that record into predictor maintenance commands. A squash command carries a sequence number, a target, a taken bit and a thread. An update command carries a sequence number and a thread.

Records for faulting instructions and for instructions that were never predicted are filtered out first. Each remaining outcome code then maps to a fixed set of commands. When an outcome needs both a squash and an update, the squash is issued in the cycle the record arrives and the update in the next cycle. During that next cycle `in_ready` is low, and any record presented then is dropped. Squash and update are therefore never active in the same cycle.

Top module: `bres_top`

## Requirements
- R1: A record with `in_fault`=1 produces no squash and no update, whatever its code.
- R2: A record with `in_tried`=0 produces no squash and no update, whatever its code.
- R3: Codes 0 (none), 5 (interrupt), 6 (suspend) and 7 (halt) produce no command.
- R4: Code 1 (unpredicted) produces a squash in the arrival cycle with the record's target and taken=1, followed in the next cycle by an update with the same sequence number and thread.
- R5: Code 2 (correctly predicted) produces only an update, in the arrival cycle, with the record's sequence number and thread.
- R6: Code 3 (wrong direction) produces a squash in the arrival cycle with taken=0 and `sq_target` driven to zero, followed in the next cycle by an update with the same sequence number and thread.
- R7: Code 4 (wrong target) produces a squash in the arrival cycle with the record's target and taken=1, and no update.
- R8: In the cycle after a code 1 or code 3 record is accepted, `in_ready` is 0 and a record presented in that cycle is dropped without any command.
- R9: After reset `in_ready` is 1 and neither strobe is active.
- R10: `sq_valid` and `up_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Resolved-branch record present |
| in_code | input | 3 | Outcome code (0 none, 1 unpredicted, 2 correct, 3 wrong direction, 4 wrong target, 5 interrupt, 6 suspend, 7 halt) |
| in_tid | input | TID_W | Thread id |
| in_seq | input | SEQ_W | Fetch sequence number |
| in_target | input | ADDR_W | Resolved target address |
| in_fault | input | 1 | Instruction carried a fault |
| in_tried | input | 1 | A prediction was attempted |
| in_ready | output | 1 | Record will be accepted this cycle |
| sq_valid | output | 1 | Squash command strobe |
| sq_seq | output | SEQ_W | Squash sequence number |
| sq_target | output | ADDR_W | Squash target (zero when not taken) |
| sq_taken | output | 1 | Squash taken bit |
| sq_tid | output | TID_W | Squash thread id |
| up_valid | output | 1 | Update command strobe |
| up_seq | output | SEQ_W | Update sequence number |
| up_tid | output | TID_W | Update thread id |

## Verification
The bench drives every code with the filter flags clear, then repeats the command-bearing codes with a fault and with no prediction attempted, so a design that forgot one of the filters would emit a stray squash or update. The two-command codes are checked cycle by cycle: a design that issued the update in the same cycle, or lost the held sequence number, fails the next-cycle check. A record presented while the pending update goes out must vanish; a design that kept `in_ready` high would issue a second command. The wrong-direction squash is checked for a zero target and a clear taken bit, and the wrong-target code for the absence of any update.

// File: rtl/bres_pkg.sv
package bres_pkg;

  typedef enum logic [2:0] {
    OC_NONE      = 3'd0,
    OC_UNPRED    = 3'd1,
    OC_CORRECT   = 3'd2,
    OC_WRONG_DIR = 3'd3,
    OC_WRONG_TGT = 3'd4,
    OC_INTR      = 3'd5,
    OC_SUSPEND   = 3'd6,
    OC_HALT      = 3'd7
  } outcome_e;

  typedef struct packed {
    logic squash;
    logic update;
    logic taken;
  } action_t;

  // Map one outcome code to the commands it calls for.
  function automatic action_t outcome_action(input outcome_e code);
    action_t a;
    a = '0;
    case (code)
      OC_UNPRED:    begin a.squash = 1'b1; a.update = 1'b1; a.taken = 1'b1; end
      OC_CORRECT:   begin a.update = 1'b1; end
      OC_WRONG_DIR: begin a.squash = 1'b1; a.update = 1'b1; a.taken = 1'b0; end
      OC_WRONG_TGT: begin a.squash = 1'b1; a.taken = 1'b1; end
      default:      a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/bres_decode.sv
module bres_decode
  import bres_pkg::*;
(
  input  logic       accept,
  input  logic [2:0] code,
  input  logic       fault,
  input  logic       tried,
  output logic       do_squash,
  output logic       do_up_now,
  output logic       do_up_later,
  output logic       squash_taken
);

  action_t act;
  logic    live;

  always_comb begin
    act          = outcome_action(outcome_e'(code));
    live         = accept && !fault && tried;
    do_squash    = live && act.squash;
    do_up_now    = live && act.update && !act.squash;
    do_up_later  = live && act.update && act.squash;
    squash_taken = act.taken;
  end

  always_comb begin
    if (fault || !tried)
      assert_filter_R1 : assert (!do_squash && !do_up_now && !do_up_later)
        else $error("filtered record produced a command (R1/R2)");
  end

endmodule

// File: rtl/bres_pend.sv
module bres_pend #(
  parameter int SEQ_W = 16,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEQ_W-1:0] load_seq,
  input  logic [TID_W-1:0] load_tid,
  output logic             pend_valid,
  output logic [SEQ_W-1:0] pend_seq,
  output logic [TID_W-1:0] pend_tid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_seq   <= '0;
      pend_tid   <= '0;
    end else begin
      pend_valid <= load;
      if (load) begin
        pend_seq <= load_seq;
        pend_tid <= load_tid;
      end
    end
  end

  assert_load_next_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pend_valid && pend_seq == $past(load_seq) && pend_tid == $past(load_tid));

  assert_single_pend_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> !load);

endmodule

// File: rtl/bres_top.sv
module bres_top #(
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_code,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [ADDR_W-1:0] in_target,
  input  logic              in_fault,
  input  logic              in_tried,
  output logic              in_ready,
  output logic              sq_valid,
  output logic [SEQ_W-1:0]  sq_seq,
  output logic [ADDR_W-1:0] sq_target,
  output logic              sq_taken,
  output logic [TID_W-1:0]  sq_tid,
  output logic              up_valid,
  output logic [SEQ_W-1:0]  up_seq,
  output logic [TID_W-1:0]  up_tid
);

  logic             accept;
  logic             do_squash, do_up_now, do_up_later, squash_taken;
  logic             pend_valid;
  logic [SEQ_W-1:0] pend_seq;
  logic [TID_W-1:0] pend_tid;

  assign in_ready = !pend_valid;
  assign accept   = in_valid && in_ready;

  bres_decode u_dec (
    .accept       (accept),
    .code         (in_code),
    .fault        (in_fault),
    .tried        (in_tried),
    .do_squash    (do_squash),
    .do_up_now    (do_up_now),
    .do_up_later  (do_up_later),
    .squash_taken (squash_taken)
  );

  bres_pend #(.SEQ_W(SEQ_W), .TID_W(TID_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (do_up_later),
    .load_seq   (in_seq),
    .load_tid   (in_tid),
    .pend_valid (pend_valid),
    .pend_seq   (pend_seq),
    .pend_tid   (pend_tid)
  );

  always_comb begin
    sq_valid  = do_squash;
    sq_seq    = do_squash ? in_seq : '0;
    sq_tid    = do_squash ? in_tid : '0;
    sq_taken  = do_squash && squash_taken;
    sq_target = (do_squash && squash_taken) ? in_target : '0;
    up_valid  = pend_valid || do_up_now;
    up_seq    = pend_valid ? pend_seq : (do_up_now ? in_seq : '0);
    up_tid    = pend_valid ? pend_tid : (do_up_now ? in_tid : '0);
  end

  assert_excl_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_valid && up_valid));

  assert_busy_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> !in_ready && !sq_valid);

  assert_pair_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    do_up_later |=> up_valid && up_seq == $past(sq_seq) && up_tid == $past(sq_tid));

  assert_zero_tgt_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !sq_taken) |-> sq_target == '0);

  assert_wrong_tgt_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_code == 3'd4 && !in_fault && in_tried) |=> !up_valid);

endmodule

// File: tb/sim_bres_top.sv
module sim_bres_top;

  localparam int SEQ_W = 16, ADDR_W = 32, TID_W = 2;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              in_valid = 1'b0, in_fault = 1'b0, in_tried = 1'b0;
  logic [2:0]        in_code = '0;
  logic [TID_W-1:0]  in_tid = '0;
  logic [SEQ_W-1:0]  in_seq = '0;
  logic [ADDR_W-1:0] in_target = '0;
  logic              in_ready, sq_valid, sq_taken, up_valid;
  logic [SEQ_W-1:0]  sq_seq, up_seq;
  logic [ADDR_W-1:0] sq_target;
  logic [TID_W-1:0]  sq_tid, up_tid;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bres_top #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TID_W(TID_W)) u0 (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected commands, restated from the requirement list.
  task automatic expect_cmds(input int code, output bit sq, output bit up_now,
                             output bit up_next, output bit taken);
    sq = 0; up_now = 0; up_next = 0; taken = 0;
    if (code == 1) begin sq = 1; taken = 1; up_next = 1; end
    if (code == 2) up_now = 1;
    if (code == 3) begin sq = 1; up_next = 1; end
    if (code == 4) begin sq = 1; taken = 1; end
  endtask

  // Present one record at a falling edge; check arrival cycle and next cycle.
  task automatic send(input string req, input int code, input bit fault, input bit tried,
                      input logic [SEQ_W-1:0] seq, input logic [TID_W-1:0] tid,
                      input logic [ADDR_W-1:0] tgt);
    bit sq, un, unx, tk;
    bit live;
    live = !fault && tried;
    expect_cmds(code, sq, un, unx, tk);
    sq &= live; un &= live; unx &= live;
    @(negedge clk);
    in_valid = 1; in_code = 3'(code); in_fault = fault; in_tried = tried;
    in_seq = seq; in_tid = tid; in_target = tgt;
    #1;
    chk(req, "in_ready", in_ready, 1);
    chk(req, "sq_valid", sq_valid, sq);
    chk(req, "up_valid", up_valid, un);
    if (sq) begin
      chk(req, "sq_seq", sq_seq, seq);
      chk(req, "sq_tid", sq_tid, tid);
      chk(req, "sq_taken", sq_taken, tk);
      chk(req, "sq_target", sq_target, tk ? tgt : '0);
    end
    if (un) begin
      chk(req, "up_seq", up_seq, seq);
      chk(req, "up_tid", up_tid, tid);
    end
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(req, "next sq_valid", sq_valid, 0);
    chk(req, "next up_valid", up_valid, unx);
    if (unx) begin
      chk(req, "next up_seq", up_seq, seq);
      chk(req, "next up_tid", up_tid, tid);
    end
  endtask

  task automatic t_reset_R9;
    #1;
    chk("R9", "in_ready", in_ready, 1);
    chk("R9", "sq_valid", sq_valid, 0);
    chk("R9", "up_valid", up_valid, 0);
  endtask

  task automatic t_quiet_codes_R3;
    send("R3", 0, 0, 1, 16'h0010, 2'd1, 32'h1000);
    send("R3", 5, 0, 1, 16'h0011, 2'd2, 32'h1004);
    send("R3", 6, 0, 1, 16'h0012, 2'd3, 32'h1008);
    send("R3", 7, 0, 1, 16'h0013, 2'd0, 32'h100C);
  endtask

  task automatic t_active_codes;
    send("R4", 1, 0, 1, 16'h0101, 2'd2, 32'hDEAD_BEE0);
    send("R5", 2, 0, 1, 16'h0202, 2'd1, 32'h0000_4440);
    send("R6", 3, 0, 1, 16'h0303, 2'd3, 32'hFFFF_FFF0);
    send("R7", 4, 0, 1, 16'h0404, 2'd0, 32'h8000_0020);
    send("R4", 1, 0, 1, 16'hFFFF, 2'd3, 32'h0000_0004);
  endtask

  task automatic t_filters;
    for (int c = 1; c <= 4; c++) begin
      send("R1", c, 1, 1, 16'h0500 + 16'(c), 2'd1, 32'h2000);
      send("R2", c, 0, 0, 16'h0600 + 16'(c), 2'd2, 32'h3000);
    end
  endtask

  task automatic t_busy_drop_R8;
    @(negedge clk);
    in_valid = 1; in_code = 3'd3; in_fault = 0; in_tried = 1;
    in_seq = 16'h0777; in_tid = 2'd1; in_target = 32'h1234;
    #1;
    chk("R8", "arrival sq_valid", sq_valid, 1);
    @(negedge clk);
    in_code = 3'd4; in_seq = 16'h0888; in_tid = 2'd2; in_target = 32'h5678;
    #1;
    chk("R8", "in_ready busy", in_ready, 0);
    chk("R8", "busy sq_valid", sq_valid, 0);
    chk("R10", "busy up_valid", up_valid, 1);
    chk("R8", "busy up_seq", up_seq, 16'h0777);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk("R8", "dropped sq_valid", sq_valid, 0);
    chk("R8", "dropped up_valid", up_valid, 0);
    chk("R8", "in_ready back", in_ready, 1);
  endtask

  task automatic t_back_to_back_R10;
    // Update-only records on consecutive cycles, then a squash-only one.
    @(negedge clk);
    in_valid = 1; in_code = 3'd2; in_fault = 0; in_tried = 1; in_seq = 16'h0901; in_tid = 2'd0;
    #1;
    chk("R5", "b2b up 1", up_valid, 1);
    @(negedge clk);
    in_seq = 16'h0902;
    #1;
    chk("R5", "b2b up_seq 2", up_seq, 16'h0902);
    @(negedge clk);
    in_code = 3'd4; in_seq = 16'h0903; in_target = 32'h40;
    #1;
    chk("R10", "squash without update", {sq_valid, up_valid}, 2'b10);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk("R7", "no later update", up_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_R9;
    rst_n = 1;
    t_quiet_codes_R3;
    t_active_codes;
    t_filters;
    t_busy_drop_R8;
    t_back_to_back_R10;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule